// File: doc/BRIEF.md
# Processor Bus Interface with Indexed Registers and Two DMA Channels

This block is the processor-facing side of a controller that holds both a host function and a device function. A processor reaches it through a 16-bit bus with an active-low chip select, two address bits, and separate active-low read and write strobes. The address bits pick one of four ports: a data port and a command port for the host side, and the same pair for the device side. Internal registers are not mapped directly. The processor first writes an 8-bit command code to a side's command port. The next data-port access on that side then moves one 16-bit word to or from the register that the code selects. Bit 7 of the code marks a write.

Each side owns a word buffer and one DMA channel with a request/acknowledge pair. Channel 0 serves the host buffer and channel 1 serves the device buffer. A channel requests service while its enable bit is set. Each word it moves is qualified by its acknowledge together with the strobe that matches the programmed direction. A transfer ends in one of two ways: the external end-of-transfer input is seen during a moved word, or an optional internal counter reaches the programmed transfer count. Either way the request drops and the enable bit clears.

Top module: `pio_dma_bus_if`

## Requirements
- R1: With `cs_n` low and no DMA acknowledge, `addr` selects the port: 0 host data, 1 host command, 2 device data, 3 device command. A data port moves a full 16-bit word. An access counts only when exactly one strobe is low.
- R2: Command ports are write-only. A read from one returns 0, and the command latched before it stays pending.
- R3: A command write latches `wdata[7:0]` as the pending code. Codes 0x21 and 0xA1 read and write the DMA configuration register. Codes 0x22 and 0xA2 read and write the transfer count register. Codes 0x40 and 0xC0 read and write the side's buffer in FIFO order. Exactly one data-port access consumes the pending code.
- R4: A data-port access with no pending code has no effect, and a read of it returns 0. An access whose direction does not match the code's bit 7 also has no effect, but it still consumes the code.
- R5: Configuration bit 0 is the DMA enable and drives `dma_req` of that side's channel. Bit 1 selects the direction, where 1 means the buffer is read out. Bit 2 enables the internal counter. All registers reset to 0.
- R6: A DMA word is moved when the channel's acknowledge is high, the channel is enabled, and the strobe for its direction is low. In a write, `wdata` enters the buffer. In a read, the next buffer word appears on `rdata`. PIO buffer accesses and DMA share the same FIFO order.
- R7: With the counter enabled, the word that brings the count to the transfer count ends the transfer. `dma_req` is low from the next cycle, and reading the configuration shows bit 0 cleared.
- R8: `dma_eot` (active high by default) high during a moved word ends that channel's transfer after the word is moved, whether or not the counter is enabled.
- R9: Any end of transfer clears the channel's word count to zero. Otherwise the count holds between transfers.
- R10: While any acknowledge is high, PIO accesses are ignored. An acknowledge on a disabled channel moves no word.
- R11: When both acknowledges are high, only channel 0 moves a word.
- R12: With no read in progress, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select for PIO |
| addr | input | 2 | Port select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 16 | Write data for PIO and DMA |
| rdata | output | 16 | Read data for PIO and DMA |
| dma_req | output | 2 | DMA request; bit 0 host channel, bit 1 device channel |
| dma_ack | input | 2 | DMA acknowledge, same bit order |
| dma_eot | input | 1 | External end of transfer |

## Verification
The bench leaves a command pending and reads the command port before the data port. A design that lets that read consume the code would then return 0 where the register value is expected. It runs a transfer that is cut short by the external input, re-enables the channel and counts the words to the next internal end. A counter that survives an end of transfer would then end early. It drives an acknowledge while a command write is on the bus, and an acknowledge on a disabled channel, then reads the buffer and registers. Either word slipping through shows up as a wrong read value. Both acknowledges are raised together, and the word must land only in the host buffer.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

   // Register indices carried in bits 6:0 of a command code; bit 7 marks a write
   localparam logic [6:0] IDX_CFG = 7'h21;
   localparam logic [6:0] IDX_TC  = 7'h22;
   localparam logic [6:0] IDX_BUF = 7'h40;

   localparam int NUM_SIDES = 2;

   typedef struct packed {
      logic cnt_en;   // bit 2
      logic dir_rd;   // bit 1
      logic en;       // bit 0
   } dma_cfg_t;

   localparam int CFG_W = $bits(dma_cfg_t);

endpackage

// File: rtl/pdb_decode.sv
module pdb_decode
   import pdb_pkg::*;
(
   input  logic                 cs_n,
   input  logic [1:0]           addr,
   input  logic                 rd_n,
   input  logic                 wr_n,
   input  logic [NUM_SIDES-1:0] dma_ack,
   output logic                 rd_act,
   output logic                 wr_act,
   output logic [NUM_SIDES-1:0] cmd_wr,
   output logic [NUM_SIDES-1:0] dat_wr,
   output logic [NUM_SIDES-1:0] dat_rd
);

   logic pio_ok;

   assign rd_act = !rd_n && wr_n;
   assign wr_act = !wr_n && rd_n;
   assign pio_ok = !cs_n && (dma_ack == '0);

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side_sel
      logic hit;
      assign hit       = pio_ok && (addr[1] == 1'(s));
      assign cmd_wr[s] = hit && addr[0] && wr_act;
      assign dat_wr[s] = hit && !addr[0] && wr_act;
      assign dat_rd[s] = hit && !addr[0] && rd_act;
   end

endmodule

// File: rtl/pdb_buffer.sv
module pdb_buffer #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head
);

   localparam int AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/pdb_dma_ctl.sv
module pdb_dma_ctl #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word,
   input  logic              cnt_en,
   input  logic              ext_eot,
   input  logic [DATA_W-1:0] tc,
   output logic              eot
);

   logic [DATA_W-1:0] count;
   logic [DATA_W-1:0] count_nxt;
   logic              hit;

   assign count_nxt = count + 1'b1;
   assign hit       = cnt_en && (count_nxt == tc);
   assign eot       = word && (hit || ext_eot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (eot)              count <= '0;
      else if (word && cnt_en)   count <= count_nxt;
   end

endmodule

// File: rtl/pdb_side.sv
module pdb_side
   import pdb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dma_word,
   input  logic              ext_eot,
   output logic [DATA_W-1:0] pio_rdata,
   output logic [DATA_W-1:0] buf_rdata,
   output logic              dma_en,
   output logic              dma_dir_rd,
   output logic              eot
);

   logic              cmd_vld;
   logic [7:0]        cmd_code;
   dma_cfg_t          cfg;
   logic [DATA_W-1:0] tc;

   logic cfg_wr, tc_wr, buf_pio_wr, buf_pio_rd;

   assign cfg_wr     = dat_wr && cmd_vld && (cmd_code == {1'b1, IDX_CFG});
   assign tc_wr      = dat_wr && cmd_vld && (cmd_code == {1'b1, IDX_TC});
   assign buf_pio_wr = dat_wr && cmd_vld && (cmd_code == {1'b1, IDX_BUF});
   assign buf_pio_rd = dat_rd && cmd_vld && (cmd_code == {1'b0, IDX_BUF});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld  <= 1'b0;
         cmd_code <= '0;
      end else if (cmd_wr) begin
         cmd_vld  <= 1'b1;
         cmd_code <= wdata[7:0];
      end else if (dat_wr || dat_rd) begin
         cmd_vld  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
         tc  <= '0;
      end else begin
         if (eot)         cfg.en <= 1'b0;
         else if (cfg_wr) cfg    <= dma_cfg_t'(wdata[CFG_W-1:0]);
         if (tc_wr)       tc     <= wdata;
      end
   end

   always_comb begin
      pio_rdata = '0;
      if (dat_rd && cmd_vld) begin
         case (cmd_code)
            {1'b0, IDX_CFG}: pio_rdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
            {1'b0, IDX_TC}:  pio_rdata = tc;
            {1'b0, IDX_BUF}: pio_rdata = buf_rdata;
            default:         pio_rdata = '0;
         endcase
      end
   end

   pdb_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (buf_pio_wr || (dma_word && !cfg.dir_rd)),
      .push_data (wdata),
      .pop       (buf_pio_rd || (dma_word && cfg.dir_rd)),
      .head      (buf_rdata)
   );

   pdb_dma_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .word    (dma_word),
      .cnt_en  (cfg.cnt_en),
      .ext_eot (ext_eot),
      .tc      (tc),
      .eot     (eot)
   );

   assign dma_en     = cfg.en;
   assign dma_dir_rd = cfg.dir_rd;

endmodule

// File: rtl/pio_dma_bus_if.sv
module pio_dma_bus_if
   import pdb_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int DEPTH           = 32,
   parameter bit EOT_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic [1:0]        addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        dma_req,
   input  logic [1:0]        dma_ack,
   input  logic              dma_eot
);

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold an 8-bit command code");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end

   logic                 rd_act, wr_act;
   logic [NUM_SIDES-1:0] pio_cmd_wr, pio_dat_wr, pio_dat_rd;
   logic [NUM_SIDES-1:0] ack_win, dma_word, side_en, side_dir, side_eot;
   logic [DATA_W-1:0]    pio_rd [NUM_SIDES];
   logic [DATA_W-1:0]    buf_rd [NUM_SIDES];
   logic                 eot_hi;

   if (EOT_ACTIVE_HIGH) begin : g_eot_hi
      assign eot_hi = dma_eot;
   end else begin : g_eot_lo
      assign eot_hi = !dma_eot;
   end

   pdb_decode u_dec (
      .cs_n    (cs_n),
      .addr    (addr),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .dma_ack (dma_ack),
      .rd_act  (rd_act),
      .wr_act  (wr_act),
      .cmd_wr  (pio_cmd_wr),
      .dat_wr  (pio_dat_wr),
      .dat_rd  (pio_dat_rd)
   );

   // lower channel index wins when both acknowledges are high
   assign ack_win[0] = dma_ack[0];
   assign ack_win[1] = dma_ack[1] && !dma_ack[0];

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      assign dma_word[s] = ack_win[s] && side_en[s] && (side_dir[s] ? rd_act : wr_act);

      pdb_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_side (
         .clk        (clk),
         .rst_n      (rst_n),
         .cmd_wr     (pio_cmd_wr[s]),
         .dat_wr     (pio_dat_wr[s]),
         .dat_rd     (pio_dat_rd[s]),
         .wdata      (wdata),
         .dma_word   (dma_word[s]),
         .ext_eot    (eot_hi),
         .pio_rdata  (pio_rd[s]),
         .buf_rdata  (buf_rd[s]),
         .dma_en     (side_en[s]),
         .dma_dir_rd (side_dir[s]),
         .eot        (side_eot[s])
      );
   end

   always_comb begin
      if (dma_word[0] && side_dir[0])      rdata = buf_rd[0];
      else if (dma_word[1] && side_dir[1]) rdata = buf_rd[1];
      else                                 rdata = pio_rd[0] | pio_rd[1];
   end

   assign dma_req = side_en;

endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              cmd_sel,
   input logic              rd_n,
   input logic              wr_n,
   input logic [1:0]        dma_ack,
   input logic [1:0]        dma_req,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        dma_word,
   input logic [1:0]        side_eot,
   input logic [1:0]        pio_dat_wr
);

   // R2
   cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && cmd_sel && !rd_n && wr_n && dma_ack == 2'b00) |-> rdata == '0);

   // R12
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_word == 2'b00 && (cs_n || rd_n)) |-> rdata == '0);

   // R7
   host_eot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      side_eot[0] |=> !dma_req[0]);

   // R8
   dev_eot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      side_eot[1] |=> !dma_req[1]);

   // R11
   ack_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack == 2'b11) |-> !dma_word[1]);

   // R5
   host_req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req[0]) |-> $past(side_eot[0] || pio_dat_wr[0]));

   // R10
   single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dma_word));

endmodule

bind pio_dma_bus_if pdb_checker #(.DATA_W(DATA_W)) u_pdb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .cmd_sel    (addr[0]),
   .rd_n       (rd_n),
   .wr_n       (wr_n),
   .dma_ack    (dma_ack),
   .dma_req    (dma_req),
   .rdata      (rdata),
   .dma_word   (dma_word),
   .side_eot   (side_eot),
   .pio_dat_wr (pio_dat_wr)
);

// File: tb/test_pio_dma_bus_if.sv
module test_pio_dma_bus_if;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic [1:0]  addr = 2'd0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  dma_req;
   logic [1:0]  dma_ack = 2'b00;
   logic        dma_eot = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit mon_en = 1'b0;

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   pio_dma_bus_if i_pio_dma_bus_if (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
      .wdata(wdata), .rdata(rdata), .dma_req(dma_req), .dma_ack(dma_ack), .dma_eot(dma_eot)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares read data just before the committing edge
   always begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      if (mon_en) begin
         exp_t e;
         if (sb_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL scoreboard empty actual=%h expected=none", rdata);
         end else begin
            e = sb_q.pop_front();
            chk(rdata, e.exp, e.tag);
         end
      end
   end

   task automatic idle();
      cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; dma_ack = 2'b00; dma_eot = 1'b0; mon_en = 1'b0;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      cs_n = 1'b0; addr = a; wr_n = 1'b0; wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic bus_read(input logic [1:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      cs_n = 1'b0; addr = a; rd_n = 1'b0;
      sb_q.push_back('{exp, tag});
      mon_en = 1'b1;
      @(negedge clk);
      idle();
   endtask

   task automatic reg_write(input bit dev, input logic [7:0] code, input logic [15:0] d);
      bus_write({dev, 1'b1}, {8'h00, code});
      bus_write({dev, 1'b0}, d);
   endtask

   task automatic reg_read(input bit dev, input logic [7:0] code, input logic [15:0] exp,
                           input string tag);
      bus_write({dev, 1'b1}, {8'h00, code});
      bus_read({dev, 1'b0}, exp, tag);
   endtask

   task automatic dma_wr(input logic [1:0] ack, input logic [15:0] d, input bit eot);
      @(negedge clk);
      dma_ack = ack; wr_n = 1'b0; wdata = d; dma_eot = eot;
      @(negedge clk);
      idle();
   endtask

   task automatic dma_rd(input logic [1:0] ack, input logic [15:0] exp, input string tag);
      @(negedge clk);
      dma_ack = ack; rd_n = 1'b0;
      sb_q.push_back('{exp, tag});
      mon_en = 1'b1;
      @(negedge clk);
      idle();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({14'd0, dma_req}, 16'h0000, "R5 reset dma_req");
      chk(rdata, 16'h0000, "R12 idle rdata");

      // R1 R3 R5: host config and device count through command then data
      reg_write(1'b0, 8'hA1, 16'h0005);
      reg_read(1'b0, 8'h21, 16'h0005, "R3 host cfg readback");
      chk({14'd0, dma_req}, 16'h0001, "R5 dma_req follows enable");
      reg_write(1'b1, 8'hA2, 16'h1234);
      reg_read(1'b1, 8'h22, 16'h1234, "R1 device tc 16-bit readback");

      // R2: command port read gives zero, pending code survives
      bus_write(2'd3, 16'h0022);
      bus_read(2'd3, 16'h0000, "R2 cmd port read zero");
      bus_read(2'd2, 16'h1234, "R2 pending kept after cmd read");
      // R4: no pending code
      bus_read(2'd2, 16'h0000, "R4 read without command");
      bus_write(2'd0, 16'h0007);
      reg_read(1'b0, 8'h21, 16'h0005, "R4 write without command ignored");
      // R4: direction mismatch
      bus_write(2'd1, 16'h0021);
      bus_write(2'd0, 16'h0000);
      bus_read(2'd0, 16'h0000, "R4 mismatch consumed code");
      reg_read(1'b0, 8'h21, 16'h0005, "R4 mismatch write ignored");

      // R3: buffer FIFO through PIO (host wr 2, rd 2)
      reg_write(1'b0, 8'hC0, 16'hAAAA);
      reg_write(1'b0, 8'hC0, 16'hBBBB);
      reg_read(1'b0, 8'h40, 16'hAAAA, "R3 buffer first word");
      reg_read(1'b0, 8'h40, 16'hBBBB, "R3 buffer second word");

      // R6 R7: host DMA write with internal count 3
      reg_write(1'b0, 8'hA2, 16'd3);
      reg_write(1'b0, 8'hA1, 16'h0005);
      dma_wr(2'b01, 16'h0101, 1'b0);
      chk({15'd0, dma_req[0]}, 16'h1, "R7 req after word 1");
      dma_wr(2'b01, 16'h0202, 1'b0);
      chk({15'd0, dma_req[0]}, 16'h1, "R7 req after word 2");
      dma_wr(2'b01, 16'h0303, 1'b0);
      chk({15'd0, dma_req[0]}, 16'h0, "R7 req drops at count");
      reg_read(1'b0, 8'h21, 16'h0004, "R7 enable bit cleared");
      reg_read(1'b0, 8'h40, 16'h0101, "R6 dma word 1 in buffer");
      reg_read(1'b0, 8'h40, 16'h0202, "R6 dma word 2 in buffer");
      reg_read(1'b0, 8'h40, 16'h0303, "R6 dma word 3 in buffer");

      // R8: device channel, counter off, ends on external input
      reg_write(1'b1, 8'hA2, 16'd2);
      reg_write(1'b1, 8'hA1, 16'h0001);
      dma_wr(2'b10, 16'h0A0A, 1'b0);
      dma_wr(2'b10, 16'h0B0B, 1'b0);
      chk({15'd0, dma_req[1]}, 16'h1, "R8 counter off ignores count");
      dma_wr(2'b10, 16'h0C0C, 1'b1);
      chk({15'd0, dma_req[1]}, 16'h0, "R8 external end drops req");
      reg_read(1'b1, 8'h21, 16'h0000, "R8 device enable cleared");
      reg_read(1'b1, 8'h40, 16'h0A0A, "R8 device word 1");
      reg_read(1'b1, 8'h40, 16'h0B0B, "R8 device word 2");
      reg_read(1'b1, 8'h40, 16'h0C0C, "R8 last word still moved");

      // R6 R7: host DMA read, count 2
      reg_write(1'b0, 8'hC0, 16'h1111);
      reg_write(1'b0, 8'hC0, 16'h2222);
      reg_write(1'b0, 8'hA2, 16'd2);
      reg_write(1'b0, 8'hA1, 16'h0007);
      dma_rd(2'b01, 16'h1111, "R6 dma read word 1");
      chk({15'd0, dma_req[0]}, 16'h1, "R7 read req held");
      dma_rd(2'b01, 16'h2222, "R6 dma read word 2");
      chk({15'd0, dma_req[0]}, 16'h0, "R7 read req drops");
      reg_read(1'b0, 8'h21, 16'h0006, "R7 read cfg after end");

      // R10: ack on disabled channel moves nothing
      dma_wr(2'b01, 16'hDEAD, 1'b0);
      reg_write(1'b0, 8'hC0, 16'h3333);
      reg_read(1'b0, 8'h40, 16'h3333, "R10 disabled channel no word");
      // R10: PIO ignored during acknowledge
      @(negedge clk);
      cs_n = 1'b0; addr = 2'd1; wr_n = 1'b1; dma_ack = 2'b10; wdata = 16'h00A1;
      wr_n = 1'b0;
      @(negedge clk);
      idle();
      bus_write(2'd0, 16'h0001);
      reg_read(1'b0, 8'h21, 16'h0006, "R10 pio command during ack ignored");

      // R11: both acknowledges
      reg_write(1'b0, 8'hA1, 16'h0001);
      reg_write(1'b1, 8'hA1, 16'h0001);
      dma_wr(2'b11, 16'h5A5A, 1'b0);
      reg_write(1'b1, 8'hC0, 16'h4444);
      reg_read(1'b1, 8'h40, 16'h4444, "R11 device took no word");
      reg_read(1'b0, 8'h40, 16'h5A5A, "R11 host took the word");

      // R9: count cleared by an external end
      reg_write(1'b0, 8'hA2, 16'd3);
      reg_write(1'b0, 8'hA1, 16'h0005);
      dma_wr(2'b01, 16'h0001, 1'b0);
      dma_wr(2'b01, 16'h0002, 1'b1);
      chk({15'd0, dma_req[0]}, 16'h0, "R9 external end mid count");
      reg_write(1'b0, 8'hA1, 16'h0005);
      dma_wr(2'b01, 16'h0003, 1'b0);
      dma_wr(2'b01, 16'h0004, 1'b0);
      chk({15'd0, dma_req[0]}, 16'h1, "R9 count restarted from zero");
      dma_wr(2'b01, 16'h0005, 1'b0);
      chk({15'd0, dma_req[0]}, 16'h0, "R9 ends after full count");

      @(negedge clk);
      chk(rdata, 16'h0000, "R12 idle rdata at end");
      chk({15'd0, sb_q.size() == 0}, 16'h1, "R3 scoreboard drained");
      finish_run();
   end

endmodule